// File: doc/BRIEF.md
# Two-Section Ripple Decade Counter

This block is a four-bit counter made of two sections that count independently. The low section is a single toggle stage. It advances on falling edges of its own count input and drives bit 0 of the output. The high section is a three-bit stage. It advances on falling edges of a second count input and drives bits 1 to 3. Its cycle length is set by a parameter to five, six or eight. Both count inputs are sampled in one system clock domain, and their falling edges are found by a two-register edge detector.

A link-mode input sets how the two sections are joined:
- **Separate (0):** the sections run on their own.
- **BCD (1):** the toggle stage carries into the high section, which gives a plain decade count.
- **Bi-quinary (2):** the top bit of the high section carries back into the toggle stage. The high section counts the input pulses, and bit 0 becomes a divide-by-ten square wave.

Two gated controls override counting while they are held:
- **Zero:** an AND of two inputs that clears all four bits.
- **Nine:** an AND of two other inputs that loads the value nine, for nine's-complement use. Nine wins over zero.

Top module: `ripple_decade`

## Requirements
- R1: While rst_n is low, q reads 0, and it stays 0 on the first cycles after release until a count event arrives.
- R2: In separate mode (link_mode=0), each falling edge of cnt_a inverts q[0]. The new value is visible on the second rising clock edge after the edge is sampled.
- R3: In separate mode, each falling edge of cnt_b steps q[3:1] by one in binary, with q[1] as the lsb. After MOD_B-1 it wraps to 0 (MOD_B=5 by default).
- R4: In BCD mode (link_mode=1), falling edges of cnt_a make q run 0,1,...,9 and then return to 0. cnt_b has no effect in this mode.
- R5: In bi-quinary mode (link_mode=2), falling edges of cnt_b step q[3:1] through 0 to 4. q[0] inverts when q[3] goes from 1 to 0. q[0] is therefore high for 5 of every 10 pulses, and cnt_a has no effect.
- R6: A rising edge on either count input, or a level held on it, does not change q.
- R7: When clr_x and clr_y are both high and the nine gate is not, q becomes 0 on the next clock edge and stays 0 while they are held. Either one alone has no effect.
- R8: When nine_x and nine_y are both high, q becomes 4'b1001 (q[0]=1, q[3]=1) on the next clock edge, even if the zero gate is also active. Either one alone has no effect.
- R9: After a gated control is released, counting continues from the value it forced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cnt_a | input | 1 | Count input of the toggle stage |
| cnt_b | input | 1 | Count input of the three-bit stage |
| link_mode | input | 2 | 0 separate, 1 BCD cascade, 2 bi-quinary cascade |
| clr_x | input | 1 | Zero gate, first leg |
| clr_y | input | 1 | Zero gate, second leg |
| nine_x | input | 1 | Nine gate, first leg |
| nine_y | input | 1 | Nine gate, second leg |
| q | output | 4 | Count value, q[0] toggle stage, q[3:1] three-bit stage |

## Verification
A directed BCD run of ten pulses checks the decade sequence and the wrap to zero. A directed bi-quinary run of twenty pulses checks q[0] against a 5-of-10 duty cycle, which shows the back-carry is taken from the falling top bit rather than a level. Random runs switch between the three link modes and mix pulses on both inputs, so a pulse on the input a mode should ignore is caught. Gate pulses are applied in the middle of counts, including single legs and both gates together, to separate the AND gating and the nine-over-zero priority from plain reset.

// File: rtl/ripple_decade.sv
module ripple_decade #(
  parameter int MOD_B = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_a,
  input  logic       cnt_b,
  input  logic [1:0] link_mode,
  input  logic       clr_x,
  input  logic       clr_y,
  input  logic       nine_x,
  input  logic       nine_y,
  output logic [3:0] q
);
  localparam int         BW       = 3;
  localparam logic [BW-1:0] TOP   = BW'(MOD_B - 1);
  localparam logic [BW-1:0] NINE_B = 3'b100;
  localparam logic [1:0] LINK_BCD = 2'd1;
  localparam logic [1:0] LINK_BIQ = 2'd2;

  logic          qa;
  logic [BW-1:0] qb, qb_nx;
  logic [1:0]    sa, sb;
  logic          fall_a, fall_b, qd_fall, ev_a, ev_b, set9, clr0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sa <= '0;
      sb <= '0;
    end else begin
      sa <= {sa[0], cnt_a};
      sb <= {sb[0], cnt_b};
    end

  assign fall_a  = sa[1] & ~sa[0];
  assign fall_b  = sb[1] & ~sb[0];
  assign qb_nx   = (qb == TOP) ? '0 : qb + 3'd1;
  assign qd_fall = qb[2] & ~qb_nx[2];
  assign set9    = nine_x & nine_y;
  assign clr0    = clr_x & clr_y;
  assign ev_a    = (link_mode == LINK_BIQ) ? (fall_b & qd_fall) : fall_a;
  assign ev_b    = (link_mode == LINK_BCD) ? (fall_a & qa) : fall_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      qa <= 1'b0;
      qb <= '0;
    end else if (set9) begin
      qa <= 1'b1;
      qb <= NINE_B;
    end else if (clr0) begin
      qa <= 1'b0;
      qb <= '0;
    end else begin
      if (ev_a) qa <= ~qa;
      if (ev_b) qb <= qb_nx;
    end

  assign q = {qb, qa};

  // R8
  nine_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_x && nine_y) |=> (q == 4'b1001));
  // R7
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_x && clr_y && !(nine_x && nine_y)) |=> (q == 4'b0000));
  // R3
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q[3:1]) < MOD_B));
  // R6
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set9 && !clr0 && !ev_a) |=> $stable(q[0]));
  // R6
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set9 && !clr0 && !ev_b) |=> $stable(q[3:1]));
  // R4
  bcd_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode == LINK_BCD && !set9 && !clr0 && fall_a && q[0]) |=> (q[0] == 1'b0 && !$stable(q[3:1])));
endmodule

// File: tb/ripple_decade_bench.sv
module ripple_decade_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MOD = 5;

  logic clk = 0, rst_n = 0, cnt_a = 0, cnt_b = 0;
  logic [1:0] link_mode = 0;
  logic clr_x = 0, clr_y = 0, nine_x = 0, nine_y = 0;
  logic [3:0] q;
  logic [3:0] m;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  ripple_decade #(.MOD_B(MOD)) u_ripple_decade (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b), .link_mode(link_mode),
    .clr_x(clr_x), .clr_y(clr_y), .nine_x(nine_x), .nine_y(nine_y), .q(q));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [2:0] bnext(input logic [2:0] b);
    return (int'(b) == MOD-1) ? 3'd0 : b + 3'd1;
  endfunction

  function automatic logic [3:0] after_a(input logic [3:0] s, input logic [1:0] md);
    case (md)
      2'd2: return s;
      2'd1: return {(s[0] ? bnext(s[3:1]) : s[3:1]), ~s[0]};
      default: return {s[3:1], ~s[0]};
    endcase
  endfunction

  function automatic logic [3:0] after_b(input logic [3:0] s, input logic [1:0] md);
    logic [2:0] nb;
    nb = bnext(s[3:1]);
    case (md)
      2'd1: return s;
      2'd2: return {nb, s[0] ^ (s[3] & ~nb[2])};
      default: return {nb, s[0]};
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, q, exp);
    end
  endtask

  task automatic pulse_a();
    cnt_a = 1; tick(3); cnt_a = 0; tick(3);
    m = after_a(m, link_mode);
  endtask

  task automatic pulse_b();
    cnt_b = 1; tick(3); cnt_b = 0; tick(3);
    m = after_b(m, link_mode);
  endtask

  initial begin
    int high;
    m = 0;
    tick(3);
    check("R1", 4'd0);
    rst_n = 1;
    tick(3);
    check("R1", 4'd0);

    // R2 / R3 separate mode
    link_mode = 0;
    pulse_a(); check("R2", m);
    pulse_a(); check("R2", m);
    for (int i = 0; i < 7; i++) begin pulse_b(); check("R3", m); end

    // R6 rising edge and held level
    cnt_a = 1; cnt_b = 1; tick(4);
    check("R6", m);
    cnt_a = 0; cnt_b = 0; tick(3);
    m = after_b(after_a(m, 0), 0);
    check("R6", m);

    // R4 BCD sequence from zero
    clr_x = 1; clr_y = 1; tick(1); check("R7", 4'd0);
    clr_x = 0; clr_y = 0; m = 0;
    link_mode = 1; tick(1);
    for (int i = 1; i <= 10; i++) begin
      pulse_a();
      check("R4", 4'(i % 10));
    end
    pulse_b(); check("R4", m);

    // R5 bi-quinary duty cycle
    clr_x = 1; clr_y = 1; tick(1);
    clr_x = 0; clr_y = 0; m = 0;
    link_mode = 2; tick(1);
    high = 0;
    for (int i = 0; i < 20; i++) begin
      pulse_b();
      check("R5", m);
      if (q[0]) high++;
    end
    checks++;
    if (high != 10) begin errors++; $display("FAIL R5 duty: actual=%0d expected=10", high); end
    pulse_a(); check("R5", m);

    // R7 / R8 gates mid-count
    link_mode = 1; pulse_a(); pulse_a();
    clr_x = 1; tick(3); check("R7", m);
    clr_x = 0; nine_y = 1; tick(3); check("R8", m);
    nine_y = 0;
    cnt_a = 1; tick(2);
    clr_x = 1; clr_y = 1; nine_x = 1; nine_y = 1; tick(1);
    check("R8", 4'b1001);
    nine_x = 0; nine_y = 0; tick(1);
    check("R7", 4'd0);
    clr_y = 0; tick(1);
    cnt_a = 0; tick(3); m = 4'd1;
    check("R9", m);
    nine_x = 1; nine_y = 1; tick(1); nine_x = 0; nine_y = 0; m = 4'b1001;
    pulse_a(); check("R9", m);

    // random mix
    for (int i = 0; i < 300; i++) begin
      if (i % 25 == 0) link_mode = 2'($urandom_range(0, 2));
      case ($urandom_range(0, 9))
        0, 1, 2, 3: begin pulse_a(); check("R2", m); end
        4, 5, 6, 7: begin pulse_b(); check("R3", m); end
        8: begin nine_x = 1; nine_y = 1; tick(2); nine_x = 0; nine_y = 0; tick(1); m = 4'b1001; check("R8", m); end
        default: begin clr_x = 1; clr_y = $urandom_range(0, 1); tick(2);
          if (clr_y) m = 0; clr_x = 0; clr_y = 0; tick(1); check("R7", m); end
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
  end
endmodule